// File: doc/BRIEF.md
# Transport Stream System Time Counter

This block keeps a 42-bit system time clock for a transport stream receiver. The low part is a 9-bit extension that counts modulo 300. The high part is a 33-bit base. Software seeds the whole counter from a received clock reference by writing two initialization words. A write to either word reloads every counter bit on the next cycle.

The base has two clock sources, chosen by a control bit. In wrap mode, the extension counts on each 27 MHz tick and the base steps when the extension rolls from 299 to 0. In strobe mode, the extension holds and the base steps once per synchronized rising edge of an external strobe. After each base step the block compares the base with a 33-bit compare value. On a match with the compare enable set, it sets a sticky status bit that drives the interrupt line.

Top module: `ts_stc_counter`

## Requirements
- R1: After reset, every readable register reads 0 and `irq` is low.
- R2: Word 2 (low init) is read/write on all 32 bits, resets to 0, and supplies base bits 31:0.
- R3: Word 3 (high init) holds base bit 32 in bit 0 and the extension init value in bits 24:16. An extension value above 299 is stored as 0. All other bits read 0.
- R4: A write to word 2 or word 3 loads the full counter from the init words on the next clock edge. This reload takes priority over any increment in that cycle.
- R5: In wrap mode (word 0 bit 1 = 0), the extension advances once per `tick_27m` cycle modulo 300. The base steps by one exactly when the extension goes from 299 to 0.
- R6: In strobe mode (word 0 bit 1 = 1), the extension holds. The base steps once per rising edge of `stc_strobe`, and the new value appears on the third clock edge after the rise.
- R7: The base wraps from 2^33-1 to 0.
- R8: With compare enable set (word 0 bit 0), the status bit is set one cycle after a base increment that makes the base equal the compare value (words 4 and 5, bit 0 of word 5 being bit 32). A match that persists without further increments sets it only once.
- R9: With compare enable clear, a match leaves the status bit at 0.
- R10: Status (word 1 bit 0) is sticky and is cleared by writing 1 to it; writing 0 has no effect. `irq` equals the status bit.
- R11: Control bits 31:2 read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from `addr` |
| tick_27m | input | 1 | 27 MHz count enable for the extension |
| stc_strobe | input | 1 | Asynchronous external base clock strobe |
| irq | output | 1 | Match interrupt, equal to the status bit |

Word 6 reads base bits 31:0. Word 7 reads base bit 32 in bit 0 and the extension in bits 24:16.

## Verification
The assertions assume two things about the inputs:
- The extension only ever holds values below 300. This holds because the register stage sanitizes the init field before it reaches the counter.
- Write strobes are synchronous to the clock. The strobe input is the only asynchronous signal.

To respect this, the bench drives every input on the falling edge and leaves `stc_strobe` high or low for several cycles at a time. It samples outputs at falling edges, counting the reload cycle and the three synchronizer edges before each expected value.

// File: rtl/stc_pkg.sv
package stc_pkg;
    localparam int BASE_W   = 33;
    localparam int EXT_W    = 9;
    localparam int EXT_MOD  = 300;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 3;
    localparam int HI_EXT_LSB = 16;
    localparam int LO_W     = DATA_W;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL    = 3'd0,
        A_STATUS  = 3'd1,
        A_INIT_LO = 3'd2,
        A_INIT_HI = 3'd3,
        A_CMP_LO  = 3'd4,
        A_CMP_HI  = 3'd5,
        A_BASE_LO = 3'd6,
        A_BASE_HI = 3'd7
    } reg_addr_e;

    typedef enum logic {
        SRC_WRAP   = 1'b0,
        SRC_STROBE = 1'b1
    } base_src_e;

    typedef struct packed {
        base_src_e src;
        logic      cmp_en;
    } ctrl_t;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [EXT_W-1:0]  ext;
    } stc_t;

    function automatic logic [DATA_W-1:0] pack_hi(logic b32, logic [EXT_W-1:0] e);
        logic [DATA_W-1:0] w;
        w = '0;
        w[0] = b32;
        w[HI_EXT_LSB +: EXT_W] = e;
        return w;
    endfunction

    function automatic logic [EXT_W-1:0] clean_ext(logic [EXT_W-1:0] e);
        return (e < EXT_W'(EXT_MOD)) ? e : '0;
    endfunction
endpackage

// File: rtl/stc_regs.sv
module stc_regs
    import stc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  stc_t              cur,
    input  logic              status,
    output ctrl_t             ctrl,
    output stc_t              init,
    output logic [BASE_W-1:0] cmp,
    output logic              load,
    output logic              clr
);
    logic [LO_W-1:0]  init_lo, cmp_lo;
    logic             init_b32, cmp_b32;
    logic [EXT_W-1:0] init_ext;
    reg_addr_e        a;

    assign a = reg_addr_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            init_lo  <= '0;
            init_b32 <= 1'b0;
            init_ext <= '0;
            cmp_lo   <= '0;
            cmp_b32  <= 1'b0;
            ctrl     <= '0;
            load     <= 1'b0;
        end else begin
            load <= wr_en && (a == A_INIT_LO || a == A_INIT_HI);
            if (wr_en) begin
                case (a)
                    A_CTRL:    ctrl <= ctrl_t'(wdata[1:0]);
                    A_INIT_LO: init_lo <= wdata;
                    A_INIT_HI: begin
                        init_b32 <= wdata[0];
                        init_ext <= clean_ext(wdata[HI_EXT_LSB +: EXT_W]);
                    end
                    A_CMP_LO:  cmp_lo <= wdata;
                    A_CMP_HI:  cmp_b32 <= wdata[0];
                    default: ;
                endcase
            end
        end
    end

    assign clr       = wr_en && (a == A_STATUS) && wdata[0];
    assign init.base = {init_b32, init_lo};
    assign init.ext  = init_ext;
    assign cmp       = {cmp_b32, cmp_lo};

    always_comb begin
        rdata = '0;
        case (a)
            A_CTRL:    rdata[1:0] = ctrl;
            A_STATUS:  rdata[0]   = status;
            A_INIT_LO: rdata      = init_lo;
            A_INIT_HI: rdata      = pack_hi(init_b32, init_ext);
            A_CMP_LO:  rdata      = cmp_lo;
            A_CMP_HI:  rdata[0]   = cmp_b32;
            A_BASE_LO: rdata      = cur.base[LO_W-1:0];
            A_BASE_HI: rdata      = pack_hi(cur.base[BASE_W-1], cur.ext);
            default:   rdata      = '0;
        endcase
    end

    // R3: the extension init value handed to the counter is always in range
    a_r3_init_ext_range: assert property (@(posedge clk) disable iff (rst)
        init.ext < EXT_W'(EXT_MOD));
endmodule

// File: rtl/stc_counter.sv
module stc_counter
    import stc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      strobe_async,
    input  base_src_e src,
    input  logic      load,
    input  stc_t      init,
    output stc_t      cnt,
    output logic      inc
);
    logic [SYNC_STAGES:0] sh;
    logic rise, ext_wrap, bump;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[SYNC_STAGES-1:0], strobe_async};
    end

    assign rise     = sh[SYNC_STAGES-1] & ~sh[SYNC_STAGES];
    assign ext_wrap = (cnt.ext == EXT_W'(EXT_MOD - 1));

    generate
        if (SYNC_STAGES > 0) begin : g_bump
            always_comb begin
                if (src == SRC_WRAP) bump = tick && ext_wrap;
                else                 bump = rise;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            inc <= 1'b0;
        end else if (load) begin
            cnt <= init;
            inc <= 1'b0;
        end else begin
            if (src == SRC_WRAP && tick)
                cnt.ext <= ext_wrap ? '0 : cnt.ext + 1'b1;
            if (bump)
                cnt.base <= cnt.base + 1'b1;
            inc <= bump;
        end
    end

    // R5: extension stays within its modulo-300 range
    a_r5_ext_range: assert property (@(posedge clk) disable iff (rst)
        cnt.ext < EXT_W'(EXT_MOD));
    // R5 / R7: extension wrap carries into the base (including base rollover)
    a_r5_wrap_carry: assert property (@(posedge clk) disable iff (rst)
        (!load && src == SRC_WRAP && tick && cnt.ext == EXT_W'(EXT_MOD - 1))
        |=> (cnt.ext == '0 && cnt.base == BASE_W'($past(cnt.base) + 1'b1)));
    // R6: strobe mode freezes the extension
    a_r6_ext_hold: assert property (@(posedge clk) disable iff (rst)
        (!load && src == SRC_STROBE) |=> $stable(cnt.ext));
    // R4: reload wins over everything
    a_r4_reload: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == $past(init)));
    // R5 / R6: base moves only on reload or step
    a_r6_base_quiet: assert property (@(posedge clk) disable iff (rst)
        (!load && !bump) |=> $stable(cnt.base));
endmodule

// File: rtl/stc_compare.sv
module stc_compare
    import stc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              inc,
    input  logic [BASE_W-1:0] base,
    input  logic [BASE_W-1:0] cmp,
    input  logic              en,
    input  logic              clr,
    output logic              status
);
    logic hit;

    assign hit = inc && en && (base == cmp);

    always_ff @(posedge clk) begin
        if (rst)      status <= 1'b0;
        else if (hit) status <= 1'b1;
        else if (clr) status <= 1'b0;
    end

    // R9: status rises only with compare enabled
    a_r9_needs_enable: assert property (@(posedge clk) disable iff (rst)
        $rose(status) |-> $past(en));
    // R8: status rises only right after a base step
    a_r8_after_step: assert property (@(posedge clk) disable iff (rst)
        $rose(status) |-> $past(inc));
    // R10: status is sticky until a clear
    a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
        (status && !clr) |=> status);
endmodule

// File: rtl/ts_stc_counter.sv
module ts_stc_counter
    import stc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              tick_27m,
    input  logic              stc_strobe,
    output logic              irq
);
    stc_t              cur, init;
    ctrl_t             ctrl;
    logic [BASE_W-1:0] cmp;
    logic              load, clr, inc, status;

    stc_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .cur(cur), .status(status), .ctrl(ctrl),
        .init(init), .cmp(cmp), .load(load), .clr(clr)
    );

    stc_counter #(.SYNC_STAGES(SYNC_STAGES)) u_cnt (
        .clk(clk), .rst(rst), .tick(tick_27m), .strobe_async(stc_strobe),
        .src(ctrl.src), .load(load), .init(init), .cnt(cur), .inc(inc)
    );

    stc_compare u_cmp (
        .clk(clk), .rst(rst), .inc(inc), .base(cur.base), .cmp(cmp),
        .en(ctrl.cmp_en), .clr(clr), .status(status)
    );

    assign irq = status;

    // R10: interrupt never disagrees with the readable status bit
    a_r10_irq_status: assert property (@(posedge clk) disable iff (rst)
        (addr == 3'd1) |-> (irq == rdata[0]));
endmodule

// File: tb/ts_stc_counter_tb.sv
`timescale 1ns/1ps
module ts_stc_counter_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        tick_27m = 1'b0;
    logic        stc_strobe = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    ts_stc_counter u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .tick_27m(tick_27m), .stc_strobe(stc_strobe), .irq(irq)
    );

    // {addr, write data, expected readback}
    localparam int NV = 8;
    localparam logic [66:0] VECS [0:NV-1] = '{
        {3'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
        {3'd2, 32'hA5A5_5A5A, 32'hA5A5_5A5A},
        {3'd3, 32'hFFFF_FFFF, 32'h0000_0001},
        {3'd3, 32'h012B_0001, 32'h012B_0001},
        {3'd4, 32'h1234_5678, 32'h1234_5678},
        {3'd5, 32'hFFFF_FFFF, 32'h0000_0001},
        {3'd0, 32'hFFFF_FFFC, 32'h0000_0000},
        {3'd0, 32'h0000_0003, 32'h0000_0003}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic get_cnt(output logic [32:0] b, output logic [8:0] e);
        logic [31:0] lo, hi;
        rd(3'd6, lo);
        rd(3'd7, hi);
        b = {hi[0], lo};
        e = hi[24:16];
    endtask

    task automatic load_cnt(input logic [32:0] b, input logic [8:0] e);
        wr(3'd2, b[31:0]);
        wr(3'd3, {7'd0, e, 15'd0, b[32]});
        step(1);
    endtask

    task automatic ticks(input int n);
        tick_27m = 1'b1;
        step(n);
        tick_27m = 1'b0;
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [32:0] b;
        logic [8:0]  e;

        step(3);
        rst = 1'b0;
        step(1);

        // R1: reset state
        for (int i = 0; i < 8; i++) begin
            rd(3'(i), d);
            chk("R1 reset readback", 64'(d), 64'd0);
        end
        chk("R1 irq low", 64'(irq), 64'd0);

        // register table: R2, R3, R11
        for (int i = 0; i < NV; i++) begin
            wr(VECS[i][66:64], VECS[i][63:32]);
            rd(VECS[i][66:64], d);
            chk("R2/R3/R11 table", 64'(d), 64'(VECS[i][31:0]));
        end
        wr(3'd0, 32'd0);

        // R5: extension counting and carry
        load_cnt(33'd5, 9'd297);
        get_cnt(b, e);
        chk("R4 load", {b, 22'd0, e}, {33'd5, 22'd0, 9'd297});
        ticks(1);
        get_cnt(b, e);
        chk("R5 ext step", {b, 22'd0, e}, {33'd5, 22'd0, 9'd298});
        ticks(2);
        get_cnt(b, e);
        chk("R5 carry", {b, 22'd0, e}, {33'd6, 22'd0, 9'd0});

        // R7: base rollover
        load_cnt(33'h1_FFFF_FFFF, 9'd299);
        ticks(1);
        get_cnt(b, e);
        chk("R7 base wrap", {b, 22'd0, e}, {33'd0, 22'd0, 9'd0});

        // R4: reload beats increment
        load_cnt(33'd0, 9'd0);
        wr(3'd2, 32'd10);
        tick_27m = 1'b1;
        wr(3'd3, {7'd0, 9'd299, 16'd0});
        step(1);
        tick_27m = 1'b0;
        get_cnt(b, e);
        chk("R4 reload priority", {b, 22'd0, e}, {33'd10, 22'd0, 9'd299});

        // R8: compare match, enabled
        wr(3'd4, 32'd6);
        wr(3'd5, 32'd0);
        wr(3'd0, 32'd1);
        load_cnt(33'd5, 9'd299);
        ticks(1);
        chk("R8 not yet set", 64'(irq), 64'd0);
        step(1);
        chk("R8 set after match", 64'(irq), 64'd1);

        // R10: sticky, write-one-to-clear
        wr(3'd1, 32'd0);
        chk("R10 write 0 keeps", 64'(irq), 64'd1);
        rd(3'd1, d);
        chk("R10 status reads 1", 64'(d), 64'd1);
        wr(3'd1, 32'd1);
        chk("R10 cleared", 64'(irq), 64'd0);
        step(5);
        chk("R8 single set", 64'(irq), 64'd0);

        // R9: compare disabled
        wr(3'd0, 32'd0);
        load_cnt(33'd5, 9'd299);
        ticks(1);
        step(2);
        get_cnt(b, e);
        chk("R9 base matched", 64'(b), 64'd6);
        chk("R9 no flag", 64'(irq), 64'd0);

        // R6: strobe mode
        wr(3'd0, 32'd2);
        load_cnt(33'd100, 9'd50);
        stc_strobe = 1'b1;
        tick_27m   = 1'b1;
        step(2);
        get_cnt(b, e);
        chk("R6 sync delay", 64'(b), 64'd100);
        step(1);
        get_cnt(b, e);
        chk("R6 step", {b, 22'd0, e}, {33'd101, 22'd0, 9'd50});
        step(5);
        get_cnt(b, e);
        chk("R6 once per edge", 64'(b), 64'd101);
        stc_strobe = 1'b0;
        step(4);
        stc_strobe = 1'b1;
        step(3);
        get_cnt(b, e);
        chk("R6 second edge", {b, 22'd0, e}, {33'd102, 22'd0, 9'd50});
        stc_strobe = 1'b0;
        tick_27m   = 1'b0;

        // R11: reserved control bits
        wr(3'd0, 32'hFFFF_FFFC);
        rd(3'd0, d);
        chk("R11 reserved zero", 64'(d), 64'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule